// File: doc/BRIEF.md
# Staged Channel Distributor

This block empties a shared stream of timed sequence entries into a bank of per-channel FIFOs before a sequence runs. Each entry names the channel it is meant for, the output level to drive and the time at which that level takes effect. The block takes entries one at a time from the source and writes each one into the FIFO of the channel it names. The channel field is removed on the way, so the channel FIFOs store only level and time.

Routing does not go through one wide select. The entry goes down a binary tree of registered levels. The first level branches on the top channel bit, and each later level branches on the next lower bit. With 16 channels the tree has four levels, and the combinational path at each level is a single two-way decision. A stall is global to the tree. When the entry in the last level faces a full channel FIFO, every level holds its contents and the source sees ready low. The source may keep valid high with a stable entry during that time, and it is accepted once ready returns. A done flag tells the controller that the source has no more data and that the tree is empty.

Top module: `fdm_tree_demux`

## Requirements
- R1: An input entry is 32 bits: channel in [31:28], level in [27], timestamp in [26:0]. The word written to a channel FIFO is the entry's bits [27:0], with the level in bit 27 and the timestamp below it.
- R2: Every accepted entry is written exactly once, into the FIFO whose index equals its channel field, and never into any other FIFO.
- R3: An entry accepted at a rising edge (in_valid and in_ready both high) has its write enable high after the third following rising edge, so the channel FIFO takes it on the fourth edge, provided in_ready stays high in between.
- R4: At most one bit of ch_wr_en is high in any cycle.
- R5: While the entry in the last level targets a channel whose full flag is high, in_ready is low, no write enable is asserted, and nothing is lost. Once the flag clears, the held entries come out in their original order.
- R6: A write enable is never high for a channel whose full flag is high.
- R7: A full flag on a channel that the last-level entry does not target has no effect on in_ready or on writes. With no full flag set, in_ready is high.
- R8: done is a register. It is high one cycle after a cycle in which in_valid is low and no tree level holds an entry. Otherwise it is low, and in particular it is low whenever a write is in progress.
- R9: While rst_n is low (active-low, synchronous), the tree holds nothing, ch_wr_en is zero, done is low and in_ready is high.
- R10: The block accepts one entry per cycle when no stall occurs. Entries for the same channel are written in the order in which they were accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Source holds an entry |
| in_ready | output | 1 | Tree can take an entry this cycle |
| in_entry | input | 32 | Entry: channel, level, timestamp |
| ch_full | input | 16 | Full flag of each channel FIFO |
| ch_wr_en | output | 16 | Write enable of each channel FIFO |
| ch_wr_data | output | 448 | 28-bit write word per channel, channel c at [28c+27:28c] |
| done | output | 1 | Source empty and tree drained |

## Verification
An entry is due on its channel's write port in the fourth cycle after it is accepted. The bench stamps each entry with a cycle counter at the negative edge before the accepting edge. The monitor then requires the counter to have advanced by exactly four when the write enable shows at a negative edge, and this check is switched off only in the phase that applies back-pressure on purpose. done is due in the sixth cycle after the last acceptance, one cycle after the final write has drained. The bench samples it at each of those six negative edges and expects it low in the first five and high in the sixth. Stall behaviour is sampled several cycles after the blocked entry has had time to reach the last level.

// File: rtl/fdm_pkg.sv
package fdm_pkg;
  localparam int unsigned FDM_NUM_CH_DEF  = 16;
  localparam int unsigned FDM_ENTRY_W_DEF = 32;

  // width of an entry as it enters tree level lvl (one channel bit dropped per level)
  function automatic int unsigned fdm_lvl_w(int unsigned entry_w, int unsigned lvl);
    return entry_w - lvl;
  endfunction
endpackage

// File: rtl/fdm_split_level.sv
module fdm_split_level #(
  parameter int unsigned IN_N = 1,
  parameter int unsigned IN_W = 32
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             adv,
  input  logic [IN_N-1:0]                  in_vld,
  input  logic [IN_N-1:0][IN_W-1:0]        in_data,
  output logic [2*IN_N-1:0]                out_vld,
  output logic [2*IN_N-1:0][IN_W-2:0]      out_data
);
  localparam int unsigned OUT_N = 2 * IN_N;

  for (genvar j = 0; j < OUT_N; j++) begin : g_slot
    localparam int unsigned PARENT = j / 2;
    localparam logic        SIDE   = 1'(j % 2);
    logic take;

    // the top remaining bit of the parent's entry picks the branch
    assign take = in_vld[PARENT] && (in_data[PARENT][IN_W-1] == SIDE);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        out_vld[j] <= 1'b0;
      end else if (adv) begin
        out_vld[j] <= take;
      end
    end

    always_ff @(posedge clk) begin
      if (adv && take) begin
        out_data[j] <= in_data[PARENT][IN_W-2:0];
      end
    end
  end
endmodule

// File: rtl/fdm_flow_ctrl.sv
module fdm_flow_ctrl #(
  parameter int unsigned NUM_CH = 16,
  parameter int unsigned LEVELS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [NUM_CH-1:0] last_vld,
  input  logic [NUM_CH-1:0] ch_full,
  input  logic [LEVELS-1:0] lvl_busy,
  output logic              adv,
  output logic              in_ready,
  output logic [NUM_CH-1:0] wr_en,
  output logic              done
);
  logic stall;
  logic done_q;

  assign stall    = |(last_vld & ch_full);
  assign adv      = !stall;
  assign in_ready = !stall;
  assign wr_en    = last_vld & {NUM_CH{!stall}};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done_q <= 1'b0;
    end else begin
      done_q <= !in_valid && !(|lvl_busy);
    end
  end

  assign done = done_q;
endmodule

// File: rtl/fdm_tree_demux.sv
module fdm_tree_demux
  import fdm_pkg::*;
#(
  parameter int unsigned NUM_CH  = FDM_NUM_CH_DEF,
  parameter int unsigned ENTRY_W = FDM_ENTRY_W_DEF,
  localparam int unsigned LEVELS = $clog2(NUM_CH),
  localparam int unsigned PAY_W  = ENTRY_W - LEVELS
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [ENTRY_W-1:0]      in_entry,
  input  logic [NUM_CH-1:0]       ch_full,
  output logic [NUM_CH-1:0]       ch_wr_en,
  output logic [NUM_CH*PAY_W-1:0] ch_wr_data,
  output logic                    done
);
  logic              adv;
  logic [LEVELS-1:0] lvl_busy;
  logic [NUM_CH-1:0] last_vld;

  for (genvar k = 0; k < LEVELS; k++) begin : g_lvl
    localparam int unsigned IN_N = 1 << k;
    localparam int unsigned IN_W = fdm_lvl_w(ENTRY_W, k);
    logic [IN_N-1:0]              iv;
    logic [IN_N-1:0][IN_W-1:0]    id;
    logic [2*IN_N-1:0]            ov;
    logic [2*IN_N-1:0][IN_W-2:0]  od;

    if (k == 0) begin : g_src
      assign iv[0] = in_valid && in_ready;
      assign id[0] = in_entry;
    end else begin : g_chain
      assign iv = g_lvl[k-1].ov;
      assign id = g_lvl[k-1].od;
    end

    fdm_split_level #(
      .IN_N (IN_N),
      .IN_W (IN_W)
    ) u_level (
      .clk      (clk),
      .rst_n    (rst_n),
      .adv      (adv),
      .in_vld   (iv),
      .in_data  (id),
      .out_vld  (ov),
      .out_data (od)
    );

    assign lvl_busy[k] = |ov;
  end

  assign last_vld = g_lvl[LEVELS-1].ov;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_port
    assign ch_wr_data[c*PAY_W +: PAY_W] = g_lvl[LEVELS-1].od[c];
  end

  fdm_flow_ctrl #(
    .NUM_CH (NUM_CH),
    .LEVELS (LEVELS)
  ) u_flow (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .last_vld (last_vld),
    .ch_full  (ch_full),
    .lvl_busy (lvl_busy),
    .adv      (adv),
    .in_ready (in_ready),
    .wr_en    (ch_wr_en),
    .done     (done)
  );
endmodule

// File: rtl/fdm_tree_demux_chk.sv
module fdm_tree_demux_chk #(
  parameter int unsigned NUM_CH = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [NUM_CH-1:0] ch_full,
  input logic [NUM_CH-1:0] ch_wr_en,
  input logic              done
);
  assert_onehot_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ch_wr_en));

  assert_no_full_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_wr_en & ch_full) == '0);

  assert_stall_blocks_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |-> (ch_wr_en == '0));

  assert_ready_free_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_full == '0) |-> in_ready);

  assert_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(in_valid && in_ready, 4) && $past(in_ready, 3) && $past(in_ready, 2)
     && $past(in_ready, 1)) |-> ((|ch_wr_en) || !in_ready));

  assert_done_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ((ch_wr_en == '0) && !$past(in_valid)));

  assert_reset_clear_R9: assert property (@(posedge clk)
    !rst_n |=> ((ch_wr_en == '0) && !done && in_ready));
endmodule

bind fdm_tree_demux fdm_tree_demux_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .ch_full  (ch_full),
  .ch_wr_en (ch_wr_en),
  .done     (done)
);

// File: tb/fdm_tree_demux_tb_top.sv
`timescale 1ns/1ps
module fdm_tree_demux_tb_top;
  localparam int NCH  = 16;
  localparam int EW   = 32;
  localparam int PW   = 28;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              in_valid = 1'b0;
  logic              in_ready;
  logic [EW-1:0]     in_entry = '0;
  logic [NCH-1:0]    ch_full = '0;
  logic [NCH-1:0]    ch_wr_en;
  logic [NCH*PW-1:0] ch_wr_data;
  logic              done;

  int  errors = 0;
  int  checks = 0;
  int  cyc = 0;
  bit  lat_chk = 1'b1;
  bit  rdy_chk = 1'b1;
  bit  finished = 1'b0;
  int  last_acc = 0;

  logic [PW-1:0] exp_d [NCH][$];
  int            exp_t [NCH][$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  fdm_tree_demux dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .in_entry   (in_entry),
    .ch_full    (ch_full),
    .ch_wr_en   (ch_wr_en),
    .ch_wr_data (ch_wr_data),
    .done       (done)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  // driver: offer one entry, wait for acceptance, record the expectation
  task automatic send(input int ch, input bit lvl, input int ts);
    bit first = 1'b1;
    @(posedge clk); #1;
    in_valid = 1'b1;
    in_entry = {4'(ch), lvl, 27'(ts)};
    forever begin
      @(negedge clk);
      if (first && rdy_chk)
        chk(in_ready, "R10/R7", "ready on offer", {63'd0, in_ready}, 64'd1);
      first = 1'b0;
      if (in_ready) break;
      @(posedge clk); #1;
    end
    exp_d[ch].push_back({lvl, 27'(ts)});
    exp_t[ch].push_back(cyc);
    last_acc = cyc;
  endtask

  task automatic go_idle();
    @(posedge clk); #1;
    in_valid = 1'b0;
  endtask

  // monitor: pop and compare each write as it shows at a negative edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (ch_wr_en != '0) begin
        chk($onehot0(ch_wr_en), "R4", "single write", {48'd0, ch_wr_en}, 64'd0);
        chk(!done, "R8", "done low during write", {63'd0, done}, 64'd0);
      end
      chk((ch_wr_en & ch_full) == '0, "R6", "write to full", {48'd0, ch_wr_en & ch_full}, 64'd0);
      for (int c = 0; c < NCH; c++) begin
        if (ch_wr_en[c]) begin
          if (exp_d[c].size() == 0) begin
            chk(1'b0, "R2", $sformatf("unexpected write ch %0d", c), {48'd0, ch_wr_en}, 64'd0);
          end else begin
            logic [PW-1:0] e;
            int t;
            e = exp_d[c].pop_front();
            t = exp_t[c].pop_front();
            chk(ch_wr_data[c*PW +: PW] == e, "R1/R2/R10", $sformatf("data ch %0d", c),
                {36'd0, ch_wr_data[c*PW +: PW]}, {36'd0, e});
            if (lat_chk)
              chk(cyc - t == 4, "R3", $sformatf("latency ch %0d", c), 64'(cyc - t), 64'd4);
          end
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    // R9: reset state
    repeat (3) @(negedge clk);
    chk(ch_wr_en == '0, "R9", "wr_en in reset", {48'd0, ch_wr_en}, 64'd0);
    chk(!done, "R9", "done in reset", {63'd0, done}, 64'd0);
    chk(in_ready, "R9", "ready in reset", {63'd0, in_ready}, 64'd1);
    @(posedge clk); #1;
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(done, "R8", "done when idle after reset", {63'd0, done}, 64'd1);

    // R1 R2 R3: one entry per channel, spaced out
    for (int c = 0; c < NCH; c++) begin
      send(c, c[0], 27'h5A5A00 + c * 97);
      go_idle();
      repeat (6) @(posedge clk);
    end

    // R10: back-to-back burst with mixed channels
    for (int i = 0; i < 32; i++) send((i * 7 + 3) % NCH, i[1], i * 1000 + i);
    go_idle();
    repeat (8) @(posedge clk);

    // R7: full on an untouched channel does not disturb traffic
    @(posedge clk); #1;
    ch_full[9] = 1'b1;
    send(3, 1'b1, 27'h7FFFFFF);
    send(3, 1'b0, 27'h0);
    send(12, 1'b1, 27'h123);
    go_idle();
    repeat (8) @(posedge clk);
    #1 ch_full[9] = 1'b0;

    // R5: back-pressure holds the tree, then releases in order
    lat_chk = 1'b0;
    rdy_chk = 1'b0;
    #1 ch_full[5] = 1'b1;
    fork
      begin
        send(5, 1'b0, 27'd11);
        send(5, 1'b1, 27'd22);
        send(2, 1'b0, 27'd33);
        send(7, 1'b1, 27'd44);
        send(5, 1'b0, 27'd55);
        send(1, 1'b1, 27'd66);
      end
      begin
        repeat (7) @(negedge clk);
        for (int k = 0; k < 8; k++) begin
          chk(!in_ready, "R5", "ready low in stall", {63'd0, in_ready}, 64'd0);
          chk(ch_wr_en == '0, "R5", "no write in stall", {48'd0, ch_wr_en}, 64'd0);
          @(negedge clk);
        end
        @(posedge clk); #1;
        ch_full[5] = 1'b0;
      end
    join
    go_idle();
    repeat (10) @(posedge clk);
    lat_chk = 1'b1;
    rdy_chk = 1'b1;

    // R8: done timing after the final acceptance
    send(14, 1'b1, 27'd777);
    go_idle();
    for (int k = 1; k <= 6; k++) begin
      @(negedge clk);
      chk(done == (k == 6), "R8", $sformatf("done at step %0d", k),
          {63'd0, done}, {63'd0, (k == 6)});
    end

    // R2: nothing left undelivered
    for (int c = 0; c < NCH; c++)
      chk(exp_d[c].size() == 0, "R2", $sformatf("leftover ch %0d", c),
          64'(exp_d[c].size()), 64'd0);
    summary();
  end
endmodule